// File: doc/BRIEF.md
# Low-Address Special Register Overlay

This block sits between a processor's load/store path and its main storage. Every request carries a word address, a direction and, for a store, a 64-bit data word. The 32 lowest word addresses never reach storage. They are served from a bank of special registers that the rest of the processor relies on. Every higher address is passed unchanged to a main-memory port. Reads are combinational, so the data comes back in the same cycle as the address.

Each special register follows its own write rule. Some bits are fixed at one or zero. Some fields are read-only to programs. The remainder, factor and channel-address registers can only be changed by dedicated strobes from the arithmetic units or the I/O side. When a program store and an internal strobe hit the same register in the same cycle, the strobe's value is kept. Field positions use big-endian bit numbering: bit 0 is the most significant bit, data bit 63.

Top module: `mmr_overlay`

## Requirements
- R1: A request with word address 0..31 drives `mem_en` and `mem_we` low. A request with address 32 or above raises `mem_en`, sets `mem_we` equal to `req_write`, and passes the address and write data through. Its read data is `mem_rdata` in the same cycle.
- R2: Address 0 always reads as 64'h0. A store to it changes nothing.
- R3: Address 12 has three bit ranges, in big-endian numbering:
  - bits 0..19 (data [63:44]) always read 1;
  - bits 20..47 (data [43:16]) hold the last value stored there;
  - bits 48..63 (data [15:0]) always read 0.
- R4: Address 5 returns a 7-bit channel field at bits 12..18 (data [51:45]). The rest of the word reads 0. Only `chan_ld` loads the field, from `chan_val`. Program stores do not change it.
- R5: Address 13 (remainder) changes only when `div_ld` loads it from `div_val`. Program stores do not change it.
- R6: Address 14 (factor) changes only when `fac_ld` loads it from `fac_val`. Program stores do not change it.
- R7: Addresses 16..31 are sixteen independent, fully writable 64-bit index registers.
- R8: Accumulator storage:
  - addresses 8 and 9 are fully writable 64-bit halves;
  - address 10 keeps an 8-bit sign byte at bits 0..7 (data [63:56]), and its other bits read 0;
  - `acc_ld` loads all three from `acc_lval`, `acc_rval` and `acc_sval`.
- R9: If a program store and an internal strobe target the same register in one cycle, the strobe's value is stored.
- R10: Reads return data in the cycle the address is presented. Stores take effect at the next rising clock edge. After reset, every special register reads 0, except the fixed ones of address 12.
- R11: Addresses 1..4, 6, 7, 11 and 15 read as 0 and ignore stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Store data |
| rd_data | output | 64 | Load data (same cycle) |
| mem_en | output | 1 | Main storage access |
| mem_we | output | 1 | Main storage write |
| mem_addr | output | ADDR_W | Main storage word address |
| mem_wdata | output | 64 | Main storage write data |
| mem_rdata | input | 64 | Main storage read data |
| chan_ld | input | 1 | I/O-side channel field load |
| chan_val | input | 7 | Channel field value |
| div_ld | input | 1 | Divide result load |
| div_val | input | 64 | Remainder value |
| fac_ld | input | 1 | Load-factor strobe |
| fac_val | input | 64 | Factor value |
| acc_ld | input | 1 | Accumulator internal load |
| acc_lval | input | 64 | Left half value |
| acc_rval | input | 64 | Right half value |
| acc_sval | input | 8 | Sign byte value |

## Verification
The following properties are checked on every cycle:
- special addresses never reach storage, and high addresses pass through intact;
- address 0 reads as zero;
- the fixed bits of the mask word hold;
- the channel, remainder and factor registers stay unchanged in every cycle without their own strobe;
- an accumulator strobe always wins.

Only the bench's scenarios can show the rest:
- the writable mask range keeps exactly what was stored;
- each index register keeps its own value;
- stores to reserved and protected addresses leave the read-back value unchanged;
- data stored through the storage port comes back on a later load.

// File: rtl/mmr_ovl_pkg.sv
package mmr_ovl_pkg;
  localparam int WORD_W       = 64;
  localparam int SPAN_W       = 5;
  localparam int NUM_IDX      = 16;
  localparam int IDX_W        = $clog2(NUM_IDX);
  // big-endian field positions converted to data indices
  localparam int CHAN_HI      = WORD_W - 1 - 12;
  localparam int CHAN_LO      = WORD_W - 1 - 18;
  localparam int CHAN_W       = CHAN_HI - CHAN_LO + 1;
  localparam int SIGN_HI      = WORD_W - 1;
  localparam int SIGN_LO      = WORD_W - 1 - 7;
  localparam int SIGN_W       = SIGN_HI - SIGN_LO + 1;
  localparam int MASK_ONE_LO  = WORD_W - 1 - 19;
  localparam int MASK_WR_HI   = WORD_W - 1 - 20;
  localparam int MASK_WR_LO   = WORD_W - 1 - 47;
  localparam int MASK_WR_W    = MASK_WR_HI - MASK_WR_LO + 1;

  typedef enum logic [3:0] {
    SEL_MEM, SEL_ZERO, SEL_CHAN, SEL_ACCL, SEL_ACCR, SEL_ACCS,
    SEL_MASK, SEL_REM, SEL_FAC, SEL_IDX, SEL_RSVD
  } sel_e;

  typedef struct packed {
    logic             special;
    sel_e             sel;
    logic [IDX_W-1:0] idx;
  } dec_t;
endpackage

// File: rtl/mmr_ovl_decode.sv
module mmr_ovl_decode
  import mmr_ovl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  logic [SPAN_W-1:0] low;

  always_comb begin
    low         = addr[SPAN_W-1:0];
    dec.special = (addr[ADDR_W-1:SPAN_W] == '0);
    dec.idx     = low[IDX_W-1:0];
    dec.sel     = SEL_MEM;
    if (dec.special) begin
      if (low[SPAN_W-1]) begin
        dec.sel = SEL_IDX;
      end else begin
        case (low[SPAN_W-2:0])
          4'd0:    dec.sel = SEL_ZERO;
          4'd5:    dec.sel = SEL_CHAN;
          4'd8:    dec.sel = SEL_ACCL;
          4'd9:    dec.sel = SEL_ACCR;
          4'd10:   dec.sel = SEL_ACCS;
          4'd12:   dec.sel = SEL_MASK;
          4'd13:   dec.sel = SEL_REM;
          4'd14:   dec.sel = SEL_FAC;
          default: dec.sel = SEL_RSVD;
        endcase
      end
    end
  end
endmodule

// File: rtl/mmr_ovl_regs.sv
module mmr_ovl_regs
  import mmr_ovl_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  dec_t                           dec,
  input  logic [WORD_W-1:0]              wdata,
  input  logic                           chan_ld,
  input  logic [CHAN_W-1:0]              chan_val,
  input  logic                           div_ld,
  input  logic [WORD_W-1:0]              div_val,
  input  logic                           fac_ld,
  input  logic [WORD_W-1:0]              fac_val,
  input  logic                           acc_ld,
  input  logic [WORD_W-1:0]              acc_lval,
  input  logic [WORD_W-1:0]              acc_rval,
  input  logic [SIGN_W-1:0]              acc_sval,
  output logic [CHAN_W-1:0]              chan_q,
  output logic [WORD_W-1:0]              accl_q,
  output logic [WORD_W-1:0]              accr_q,
  output logic [SIGN_W-1:0]              accs_q,
  output logic [MASK_WR_W-1:0]           mask_q,
  output logic [WORD_W-1:0]              rem_q,
  output logic [WORD_W-1:0]              fac_q,
  output logic [NUM_IDX-1:0][WORD_W-1:0] idx_q
);
  logic pw;
  logic accl_en, accr_en, accs_en, mask_en;
  logic [WORD_W-1:0]    accl_d, accr_d;
  logic [SIGN_W-1:0]    accs_d;
  logic [MASK_WR_W-1:0] mask_d;

  // next-state: internal strobes take priority over program stores
  always_comb begin
    pw      = wr_en && dec.special;
    accl_en = acc_ld || (pw && dec.sel == SEL_ACCL);
    accr_en = acc_ld || (pw && dec.sel == SEL_ACCR);
    accs_en = acc_ld || (pw && dec.sel == SEL_ACCS);
    mask_en = pw && dec.sel == SEL_MASK;
    accl_d  = acc_ld ? acc_lval : wdata;
    accr_d  = acc_ld ? acc_rval : wdata;
    accs_d  = acc_ld ? acc_sval : wdata[SIGN_HI:SIGN_LO];
    mask_d  = wdata[MASK_WR_HI:MASK_WR_LO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      accl_q <= '0;
      accr_q <= '0;
      accs_q <= '0;
      mask_q <= '0;
      rem_q  <= '0;
      fac_q  <= '0;
    end else begin
      if (chan_ld) chan_q <= chan_val;
      if (accl_en) accl_q <= accl_d;
      if (accr_en) accr_q <= accr_d;
      if (accs_en) accs_q <= accs_d;
      if (mask_en) mask_q <= mask_d;
      if (div_ld)  rem_q  <= div_val;
      if (fac_ld)  fac_q  <= fac_val;
    end
  end

  for (genvar i = 0; i < NUM_IDX; i++) begin : g_idx
    logic en;
    always_comb en = pw && dec.sel == SEL_IDX && dec.idx == IDX_W'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  idx_q[i] <= '0;
      else if (en) idx_q[i] <= wdata;
    end
  end

  assert_chan_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_ld |=> $stable(chan_q));
  assert_rem_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !div_ld |=> $stable(rem_q));
  assert_fac_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fac_ld |=> $stable(fac_q));
  assert_acc_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ld |=> (accl_q == $past(acc_lval) && accs_q == $past(acc_sval)));
endmodule

// File: rtl/mmr_ovl_rdmux.sv
module mmr_ovl_rdmux
  import mmr_ovl_pkg::*;
(
  input  dec_t                           dec,
  input  logic [CHAN_W-1:0]              chan_q,
  input  logic [WORD_W-1:0]              accl_q,
  input  logic [WORD_W-1:0]              accr_q,
  input  logic [SIGN_W-1:0]              accs_q,
  input  logic [MASK_WR_W-1:0]           mask_q,
  input  logic [WORD_W-1:0]              rem_q,
  input  logic [WORD_W-1:0]              fac_q,
  input  logic [NUM_IDX-1:0][WORD_W-1:0] idx_q,
  input  logic [WORD_W-1:0]              mem_rdata,
  output logic [WORD_W-1:0]              rd_data
);
  logic [WORD_W-1:0] sp;

  always_comb begin
    sp = '0;
    case (dec.sel)
      SEL_CHAN: sp[CHAN_HI:CHAN_LO] = chan_q;
      SEL_ACCL: sp = accl_q;
      SEL_ACCR: sp = accr_q;
      SEL_ACCS: sp[SIGN_HI:SIGN_LO] = accs_q;
      SEL_MASK: begin
        sp[WORD_W-1:MASK_ONE_LO]      = '1;
        sp[MASK_WR_HI:MASK_WR_LO]     = mask_q;
      end
      SEL_REM:  sp = rem_q;
      SEL_FAC:  sp = fac_q;
      SEL_IDX:  sp = idx_q[dec.idx];
      default:  sp = '0;
    endcase
    rd_data = dec.special ? sp : mem_rdata;
  end
endmodule

// File: rtl/mmr_overlay.sv
module mmr_overlay
  import mmr_ovl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic [63:0]       rd_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  input  logic              chan_ld,
  input  logic [6:0]        chan_val,
  input  logic              div_ld,
  input  logic [63:0]       div_val,
  input  logic              fac_ld,
  input  logic [63:0]       fac_val,
  input  logic              acc_ld,
  input  logic [63:0]       acc_lval,
  input  logic [63:0]       acc_rval,
  input  logic [7:0]        acc_sval
);
  localparam logic [ADDR_W-1:0] SPAN_END = ADDR_W'(1 << SPAN_W);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  dec_t       dec;
  logic       prog_wr;

  logic [CHAN_W-1:0]              chan_q;
  logic [WORD_W-1:0]              accl_q, accr_q, rem_q, fac_q;
  logic [SIGN_W-1:0]              accs_q;
  logic [MASK_WR_W-1:0]           mask_q;
  logic [NUM_IDX-1:0][WORD_W-1:0] idx_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mmr_ovl_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(req_addr), .dec(dec));

  always_comb begin
    prog_wr   = req_valid && req_write;
    mem_en    = req_valid && !dec.special;
    mem_we    = mem_en && req_write;
    mem_addr  = req_addr;
    mem_wdata = req_wdata;
  end

  mmr_ovl_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(prog_wr), .dec(dec), .wdata(req_wdata),
    .chan_ld(chan_ld), .chan_val(chan_val), .div_ld(div_ld), .div_val(div_val),
    .fac_ld(fac_ld), .fac_val(fac_val), .acc_ld(acc_ld), .acc_lval(acc_lval),
    .acc_rval(acc_rval), .acc_sval(acc_sval), .chan_q(chan_q), .accl_q(accl_q),
    .accr_q(accr_q), .accs_q(accs_q), .mask_q(mask_q), .rem_q(rem_q),
    .fac_q(fac_q), .idx_q(idx_q)
  );

  mmr_ovl_rdmux u_mux (
    .dec(dec), .chan_q(chan_q), .accl_q(accl_q), .accr_q(accr_q), .accs_q(accs_q),
    .mask_q(mask_q), .rem_q(rem_q), .fac_q(fac_q), .idx_q(idx_q),
    .mem_rdata(mem_rdata), .rd_data(rd_data)
  );

  assert_special_no_mem_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_addr < SPAN_END) |-> (!mem_en && !mem_we));
  assert_mem_pass_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_addr >= SPAN_END) |->
      (mem_en && mem_we == req_write && mem_addr == req_addr && rd_data == mem_rdata));
  assert_zero_read_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_addr == '0) |-> rd_data == '0);
  assert_mask_fixed_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_addr == ADDR_W'(12)) |->
      (rd_data[63:44] == '1 && rd_data[15:0] == '0));
endmodule

// File: tb/mmr_overlay_tb.sv
module mmr_overlay_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rd_data, mem_wdata, mem_rdata;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic        chan_ld = 0, div_ld = 0, fac_ld = 0, acc_ld = 0;
  logic [6:0]  chan_val = '0;
  logic [63:0] div_val = '0, fac_val = '0, acc_lval = '0, acc_rval = '0;
  logic [7:0]  acc_sval = '0;

  int checks = 0, failures = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] mem_model [64];
  bit          finished = 0;

  localparam logic [63:0] MASK_FIX = 64'hFFFF_F000_0000_0000;
  localparam logic [63:0] MASK_WR  = 64'h0000_0FFF_FFFF_0000;

  always #2 clk = ~clk;

  mmr_overlay u_dut (.*);

  assign mem_rdata = mem_model[mem_addr[5:0]];
  always @(posedge clk) if (mem_we) mem_model[mem_addr[5:0]] <= mem_wdata;

  task automatic clr();
    req_valid = 0; req_write = 0;
    chan_ld = 0; div_ld = 0; fac_ld = 0; acc_ld = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [63:0] e, input string t);
    @(posedge clk); #1; clr();
    req_valid = 1; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    @(posedge clk); #1; clr();
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
  endtask

  task automatic strobe_only();
    @(posedge clk); #1; clr();
  endtask

  task automatic chk(input logic [63:0] act, input logic [63:0] e, input string t);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && req_valid && !req_write) begin
      if (exp_q.size() == 0) chk(rd_data, 64'hx, "scoreboard empty");
      else chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem_model[i] = 64'hA5A5_0000_0000_0000 | 64'(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);

    // R10 reset values
    rd(0,  '0, "R10 reset zero");
    rd(12, MASK_FIX, "R10 reset mask");
    rd(13, '0, "R10 reset rem");
    rd(8,  '0, "R10 reset accl");
    rd(20, '0, "R10 reset idx");

    // R2
    wr(0, '1);
    rd(0, '0, "R2 zero after store");

    // R3
    wr(12, '1);
    rd(12, MASK_FIX | MASK_WR, "R3 mask all ones");
    wr(12, '0);
    rd(12, MASK_FIX, "R3 mask cleared");
    wr(12, 64'h0123_4567_89AB_CDEF);
    rd(12, MASK_FIX | (64'h0123_4567_89AB_CDEF & MASK_WR), "R3 mask pattern");

    // R4
    wr(5, '1);
    rd(5, '0, "R4 chan store ignored");
    strobe_only(); chan_ld = 1; chan_val = 7'h5A;
    rd(5, 64'(7'h5A) << 45, "R4 chan strobe");
    wr(5, '0);
    rd(5, 64'(7'h5A) << 45, "R4 chan kept");

    // R5, R6
    wr(13, 64'h1111);
    rd(13, '0, "R5 rem store ignored");
    strobe_only(); div_ld = 1; div_val = 64'hDEAD_BEEF_0000_0013;
    rd(13, 64'hDEAD_BEEF_0000_0013, "R5 rem strobe");
    wr(14, 64'h2222);
    rd(14, '0, "R6 fac store ignored");
    strobe_only(); fac_ld = 1; fac_val = 64'hFACE_0000_0000_0014;
    wr(14, '1);
    rd(14, 64'hFACE_0000_0000_0014, "R6 fac strobe");

    // R7
    for (int i = 0; i < 16; i++) wr(16'(16 + i), {8'(i), 56'h0, 8'(~i)});
    for (int i = 0; i < 16; i++) rd(16'(16 + i), {8'(i), 56'h0, 8'(~i)}, "R7 index reg");

    // R8
    wr(8, 64'h8888_0000_0000_0001);
    wr(9, 64'h9999_0000_0000_0002);
    wr(10, '1);
    rd(8, 64'h8888_0000_0000_0001, "R8 acc left");
    rd(9, 64'h9999_0000_0000_0002, "R8 acc right");
    rd(10, 64'hFF00_0000_0000_0000, "R8 sign byte");
    strobe_only(); acc_ld = 1; acc_lval = 64'h1; acc_rval = 64'h2; acc_sval = 8'h3C;
    rd(9, 64'h2, "R8 acc strobe right");
    rd(10, 64'h3C00_0000_0000_0000, "R8 acc strobe sign");

    // R9 collision: program store and strobe same cycle
    wr(8, 64'hBAD0); acc_ld = 1; acc_lval = 64'h600D;
    rd(8, 64'h600D, "R9 strobe wins acc");
    wr(5, '1); chan_ld = 1; chan_val = 7'h03;
    rd(5, 64'(7'h03) << 45, "R9 strobe wins chan");

    // R11 reserved
    wr(3, '1);  rd(3, '0, "R11 addr3");
    wr(11, '1); rd(11, '0, "R11 addr11");
    wr(15, '1); rd(15, '0, "R11 addr15");

    // R1 pass-through
    wr(40, 64'hCAFE_F00D_1234_5678);
    @(negedge clk);
    chk(64'({mem_en, mem_we}), 64'h3, "R1 mem strobes on store");
    chk(64'(mem_addr), 64'd40, "R1 mem addr");
    chk(mem_wdata, 64'hCAFE_F00D_1234_5678, "R1 mem wdata");
    rd(40, 64'hCAFE_F00D_1234_5678, "R1 mem readback");
    @(negedge clk);
    chk(64'({mem_en, mem_we}), 64'h2, "R1 mem read strobes");
    rd(33, 64'hA5A5_0000_0000_0021, "R1 mem preset");
    wr(20, '0);
    @(negedge clk);
    chk(64'({mem_en, mem_we}), 64'h0, "R1 special no mem");
    rd(20, '0, "R10 store visible next cycle");

    strobe_only();
    repeat (3) @(posedge clk);
    chk(64'(exp_q.size()), 0, "scoreboard drained");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule